// File: doc/BRIEF.md
# GPIO Port Debounce Unit

This block filters the inputs of one eight-pin GPIO port so that contact bounce and short glitches do not reach the logic behind it. Each raw pin passes through a two-flop synchroniser. When filtering is on for a pin, the pin's output takes a new level only after the synchronised input has held that level for a programmed number of millisecond ticks. When filtering is off, the synchronised input goes straight to the output. A divider set by a parameter turns the system clock into a free-running millisecond tick.

Software sets the filter through a simple register bus with a write strobe, a read strobe, an 8-bit offset and 16-bit data. One 8-bit count register holds the stability time in milliseconds, and all eight pins share it. The per-pin enables have no plain read-write register. They change only through a masked write: the upper data byte chooses which pins to update and the lower byte gives their new values. To turn filtering off, software clears the pin's enable and does not touch the count. Each pin takes a copy of the count when a stability window opens. A count written during a window therefore takes effect from the next window.

Top module: `gpio_port_debounce`

## Requirements
- R1: After reset the count register is 0, every enable bit is 0, every filtered output is 0, and reads of both registers return 0x0000.
- R2: A write to offset 0xF0 loads wdata[7:0] into the count register and ignores wdata[15:8]. A read of 0xF0 returns the count in bits 7:0 and zeros in bits 15:8.
- R3: A write to offset 0xB0 updates enable bit i only where wdata[8+i] is 1, setting it to wdata[i]. Enable bits whose mask bit is 0 keep their value. A read of 0xB0 returns the enables in bits 7:0 and zeros in bits 15:8. No other access changes the enables.
- R4: With a pin's enable at 0, a change on its raw input appears on its filtered output on the third rising clock edge after the change (two synchroniser stages, then the output register).
- R5: With a pin's enable at 1 and count N ≥ 1, after a raw change held steady the filtered output keeps its old level through clock edge (N-1)*D+2 and shows the new level by edge N*D+2, where D is the tick divider in clocks.
- R6: With the enable at 1, a raw pulse shorter than the stability window never reaches the filtered output.
- R7: A count written while a pin's stability window is open does not change that window. The new count applies from the next window.
- R8: When a pin's enable is cleared, its filtered output follows the synchronised raw input from the clock after the enable register changes, and the count register keeps its value.
- R9: The millisecond tick fires once every D clocks. An enabled pin's filtered output changes only on a clock edge that has a tick.
- R10: With the enable at 1 and a count of 0, a held raw change appears on the output at the first tick after the change has been synchronised (old level through edge 2, new level by edge D+2).
- R11: The largest count, 255, can be read back and gives a window of 255 ticks, with the same bounds as R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_rd | input | 1 | Register read strobe; read data is combinational |
| reg_addr | input | 8 | Register offset in the port window |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, zero when reg_rd is low |
| pin_raw | input | NUM_PINS | Raw, asynchronous pin inputs |
| pin_filt | output | NUM_PINS | Filtered (or passed-through) pin levels |

## Verification
The hardest case to reach from the ports is a count written in the middle of an open stability window. To show that the pin keeps its earlier copy of the count, the bench toggles a raw input, waits a few clocks so the window is open, then writes a much larger count. It checks that the output still switches within the short-count bounds, and that the following window uses the long count. The tick runs free, so its phase within a window is unknown. Each timing check therefore brackets the output between a "still old" cycle and a "surely new" cycle that hold for any tick phase. The enable-clear case is reached by opening a long window, clearing the enable in the middle of it, and then expecting pass-through on the second clock after the write.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 16;
   localparam int MASK_LSB = 8;
   localparam logic [ADDR_W-1:0] OFS_EN_MASKED = 8'hB0;
   localparam logic [ADDR_W-1:0] OFS_COUNT = 8'hF0;

   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_COUNT = 2'd1,
      SEL_EN    = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/dbnc_sync.sv
module dbnc_sync #(
   parameter int W = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage_q [STAGES];

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[g] <= '0;
               else        stage_q[g] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[g] <= '0;
               else        stage_q[g] <= stage_q[g-1];
            end
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dbnc_tick.sv
module dbnc_tick #(
   parameter int DIV = 100000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            div_q <= '0;
      else if (div_q == LAST) div_q <= '0;
      else                   div_q <= div_q + 1'b1;
   end

   assign tick = (div_q == LAST);
endmodule

// File: rtl/dbnc_regs.sv
module dbnc_regs
   import dbnc_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int CNT_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   output logic [CNT_W-1:0]    count_q,
   output logic [NUM_PINS-1:0] en_q
);
   reg_sel_e sel;
   logic [NUM_PINS-1:0] wr_mask;
   logic [NUM_PINS-1:0] wr_val;

   always_comb begin
      case (reg_addr)
         OFS_COUNT:     sel = SEL_COUNT;
         OFS_EN_MASKED: sel = SEL_EN;
         default:       sel = SEL_NONE;
      endcase
   end

   assign wr_mask = reg_wdata[MASK_LSB +: NUM_PINS];
   assign wr_val  = reg_wdata[0 +: NUM_PINS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (reg_wr && sel == SEL_COUNT) begin
         count_q <= reg_wdata[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (reg_wr && sel == SEL_EN) begin
         en_q <= (en_q & ~wr_mask) | (wr_val & wr_mask);
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_rd) begin
         case (sel)
            SEL_COUNT: reg_rdata = DATA_W'(count_q);
            SEL_EN:    reg_rdata = DATA_W'(en_q);
            default:   reg_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/dbnc_filter.sv
module dbnc_filter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             tick,
   input  logic [CNT_W-1:0] cfg_count,
   input  logic             din,
   output logic             dout
);
   logic [CNT_W-1:0] run_q;
   logic [CNT_W-1:0] lim_q;
   logic [CNT_W:0]   run_nxt;
   logic             mismatch;

   assign mismatch = (din != dout);
   assign run_nxt  = {1'b0, run_q} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout  <= 1'b0;
         run_q <= '0;
         lim_q <= '0;
      end else if (!en) begin
         dout  <= din;
         run_q <= '0;
         lim_q <= cfg_count;
      end else if (!mismatch) begin
         run_q <= '0;
         lim_q <= cfg_count;
      end else if (tick) begin
         if (run_nxt >= {1'b0, lim_q}) begin
            dout  <= din;
            run_q <= '0;
            lim_q <= cfg_count;
         end else begin
            run_q <= run_nxt[CNT_W-1:0];
         end
      end
   end
endmodule

// File: rtl/gpio_port_debounce.sv
module gpio_port_debounce
   import dbnc_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int CNT_W = 8,
   parameter int CLK_PER_MS = 100000,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   input  logic [NUM_PINS-1:0] pin_raw,
   output logic [NUM_PINS-1:0] pin_filt
);
   if (NUM_PINS < 1 || NUM_PINS > MASK_LSB) begin : g_bad_pins
      $error("NUM_PINS must fit in the low data byte");
   end
   if (CNT_W < 1 || CNT_W > MASK_LSB) begin : g_bad_cnt
      $error("CNT_W must fit in the low data byte");
   end
   if (CLK_PER_MS < 2) begin : g_bad_div
      $error("CLK_PER_MS must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [CNT_W-1:0]    count_q;
   logic [NUM_PINS-1:0] en_q;
   logic [NUM_PINS-1:0] pin_sync;
   logic                ms_tick;

   dbnc_regs #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .count_q(count_q), .en_q(en_q)
   );

   dbnc_tick #(.DIV(CLK_PER_MS)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick)
   );

   dbnc_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_sync)
   );

   genvar p;
   generate
      for (p = 0; p < NUM_PINS; p++) begin : g_pin
         dbnc_filter #(.CNT_W(CNT_W)) u_filt (
            .clk(clk), .rst_n(rst_n),
            .en(en_q[p]), .tick(ms_tick), .cfg_count(count_q),
            .din(pin_sync[p]), .dout(pin_filt[p])
         );
      end
   endgenerate
endmodule

// File: rtl/dbnc_chk.sv
module dbnc_chk
   import dbnc_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int CNT_W = 8,
   parameter int CLK_PER_MS = 100000
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_wr,
   input logic                reg_rd,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic [DATA_W-1:0]   reg_wdata,
   input logic [DATA_W-1:0]   reg_rdata,
   input logic [NUM_PINS-1:0] pin_filt,
   input logic [NUM_PINS-1:0] en_q,
   input logic [CNT_W-1:0]    count_q,
   input logic [NUM_PINS-1:0] pin_sync,
   input logic                ms_tick
);
   localparam int GAP_W = $clog2(CLK_PER_MS) + 1;
   logic [GAP_W-1:0] gap_q;
   logic             seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (ms_tick) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
      end else begin
         gap_q <= gap_q + 1'b1;
      end
   end

   AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (ms_tick && seen_q) |-> (gap_q == GAP_W'(CLK_PER_MS - 1))); // R9

   AST_CHANGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ms_tick) |-> (((pin_filt ^ $past(pin_filt)) & $past(en_q)) == '0)); // R9

   AST_DISABLED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((pin_filt ^ $past(pin_sync)) & ~$past(en_q)) == '0)); // R8

   AST_EN_ONLY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(reg_wr && reg_addr == OFS_EN_MASKED) |-> $stable(en_q)); // R3

   AST_EN_UNMASKED_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reg_wr && reg_addr == OFS_EN_MASKED) |->
         (((en_q ^ $past(en_q)) & ~$past(reg_wdata[MASK_LSB +: NUM_PINS])) == '0)); // R3

   AST_COUNT_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(reg_wr && reg_addr == OFS_COUNT) |-> $stable(count_q)); // R2

   AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd |-> (reg_rdata[DATA_W-1:MASK_LSB] == '0)); // R3
endmodule

bind gpio_port_debounce dbnc_chk #(
   .NUM_PINS(NUM_PINS), .CNT_W(CNT_W), .CLK_PER_MS(CLK_PER_MS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
   .pin_filt(pin_filt), .en_q(en_q), .count_q(count_q),
   .pin_sync(pin_sync), .ms_tick(ms_tick)
);

// File: tb/gpio_port_debounce_tb.sv
module gpio_port_debounce_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DIV = 4;
   localparam logic [7:0] A_CNT = 8'hF0;
   localparam logic [7:0] A_EN  = 8'hB0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [7:0]  raw = '0;
   logic [7:0]  pin_filt;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   typedef struct {
      int         at;
      logic [7:0] mask;
      logic [7:0] val;
      string      tag;
   } exp_t;
   exp_t sb_q[$];

   gpio_port_debounce #(.CLK_PER_MS(DIV)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pin_raw(raw), .pin_filt(pin_filt)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // Scoreboard monitor: compares queued expectations at their cycle
   always @(negedge clk) begin
      while (sb_q.size() > 0 && sb_q[0].at <= cyc) begin
         n_chk++;
         if (sb_q[0].at < cyc) begin
            n_fail++;
            $display("FAIL %s: expectation for cycle %0d missed at %0d, expected %h",
                     sb_q[0].tag, sb_q[0].at, cyc, sb_q[0].val);
         end else if ((pin_filt & sb_q[0].mask) != sb_q[0].val) begin
            n_fail++;
            $display("FAIL %s: cycle %0d pin_filt&%h = %h expected %h", sb_q[0].tag,
                     cyc, sb_q[0].mask, pin_filt & sb_q[0].mask, sb_q[0].val);
         end
         void'(sb_q.pop_front());
      end
   end

   task automatic push(input int at, input logic [7:0] m, input logic [7:0] v, input string tag);
      exp_t e;
      e.at = at; e.mask = m; e.val = v; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [15:0] exp, input string tag);
      reg_rd = 1'b1; reg_addr = a;
      #1;
      n_chk++;
      if (reg_rdata != exp) begin
         n_fail++;
         $display("FAIL %s: read %h = %h expected %h", tag, a, reg_rdata, exp);
      end
      reg_rd = 1'b0;
   endtask

   task automatic filt_chk(input logic [7:0] exp, input string tag);
      n_chk++;
      if (pin_filt != exp) begin
         n_fail++;
         $display("FAIL %s: pin_filt = %h expected %h", tag, pin_filt, exp);
      end
   endtask

   initial begin
      int c;
      int w;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      filt_chk(8'h00, "R1");
      rd_chk(A_CNT, 16'h0000, "R1");
      rd_chk(A_EN, 16'h0000, "R1");

      // R4 pass-through with enable off
      c = cyc; raw = 8'h80;
      push(c + 2, 8'h80, 8'h00, "R4");
      push(c + 3, 8'h80, 8'h80, "R4");
      idle(6);

      // R3 masked enable writes
      wr(A_EN, 16'h0F05);
      rd_chk(A_EN, 16'h0005, "R3");
      wr(A_EN, 16'hF0FF);
      rd_chk(A_EN, 16'h00F5, "R3");
      wr(A_EN, 16'h01FE);
      rd_chk(A_EN, 16'h00F4, "R3");
      wr(A_EN, 16'hFF07);
      rd_chk(A_EN, 16'h0007, "R3");

      // R2 count register
      wr(A_CNT, 16'h0003);
      rd_chk(A_CNT, 16'h0003, "R2");
      wr(A_CNT, 16'hAB03);
      rd_chk(A_CNT, 16'h0003, "R2");
      rd_chk(A_EN, 16'h0007, "R2");
      idle(2);

      // R5 window timing, count 3, both edges on pin 0
      c = cyc; raw[0] = 1'b1;
      push(c + 2*DIV + 2, 8'h01, 8'h00, "R5");
      push(c + 3*DIV + 2, 8'h01, 8'h01, "R5");
      idle(20);
      c = cyc; raw[0] = 1'b0;
      push(c + 2*DIV + 2, 8'h01, 8'h01, "R5");
      push(c + 3*DIV + 2, 8'h01, 8'h00, "R5");
      idle(20);

      // R6 short glitch on pin 2 is rejected
      c = cyc; raw[2] = 1'b1;
      push(c + 5, 8'h04, 8'h00, "R6");
      push(c + 20, 8'h04, 8'h00, "R6");
      idle(2);
      raw[2] = 1'b0;
      idle(22);

      // R7 count written mid-window on pin 1
      c = cyc; raw[1] = 1'b1;
      push(c + 2*DIV + 2, 8'h02, 8'h00, "R7");
      push(c + 3*DIV + 2, 8'h02, 8'h02, "R7");
      idle(4);
      wr(A_CNT, 16'h000A);
      idle(14);
      rd_chk(A_CNT, 16'h000A, "R7");
      c = cyc; raw[1] = 1'b0;
      push(c + 9*DIV + 2, 8'h02, 8'h02, "R7");
      push(c + 10*DIV + 2, 8'h02, 8'h00, "R7");
      idle(46);

      // R8 clear enable mid-window on pin 0
      c = cyc; raw[0] = 1'b1;
      idle(8);
      w = cyc;
      push(w + 1, 8'h01, 8'h00, "R8");
      push(w + 2, 8'h01, 8'h01, "R8");
      wr(A_EN, 16'h0100);
      idle(4);
      rd_chk(A_CNT, 16'h000A, "R8");
      rd_chk(A_EN, 16'h0006, "R8");

      // R10 count zero while enabled
      wr(A_EN, 16'h0101);
      wr(A_CNT, 16'h0000);
      idle(2);
      c = cyc; raw[0] = 1'b0;
      push(c + 2, 8'h01, 8'h01, "R10");
      push(c + DIV + 2, 8'h01, 8'h00, "R10");
      idle(10);

      // R11 maximum count
      wr(A_CNT, 16'h00FF);
      rd_chk(A_CNT, 16'h00FF, "R11");
      idle(2);
      c = cyc; raw[0] = 1'b1;
      push(c + 254*DIV + 2, 8'h01, 8'h00, "R11");
      push(c + 255*DIV + 2, 8'h01, 8'h01, "R11");
      // R9 other enabled pins stay put meanwhile
      push(c + 255*DIV + 2, 8'h86, 8'h80, "R9");
      idle(255*DIV + 6);

      while (sb_q.size() > 0) idle(1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule